// File: doc/BRIEF.md
# Receive Sample Demapper for a Two-Lane Serial Converter Link

This block sits after lane alignment and descrambling on the receive side of a serial converter link. Each of two lanes delivers one octet per cycle, with a per-lane valid and a per-lane frame-start strobe. The block collects one frame of octets from every lane in use. It then rebuilds 16-bit samples and hands them out as a vector indexed by stream number, together with a one-cycle valid strobe.

A mode number picks the frame geometry: the octets per lane per frame and the largest stream count the mode allows. The programmed stream count M then sets how many lanes carry data, so a link with few streams runs on a single lane. A sample-interleave factor SI selects a strided order for the samples that share a stream within a frame. An unsupported mode, or a stream count outside the mode's range, is flagged and stops all output.

Top module: `rx_sample_demap`

## Requirements
- R1: After reset, `smp_o` is all zero, and `smp_vld_o` and `cfg_err_o` are low.
- R2: The mode numbers map as follows: 4 gives 2 octets per lane per frame and at most 2 streams; 5 gives 4 octets and at most 4 streams; 6 gives 8 octets and at most 8 streams. Every mode has at most 2 lanes and carries 16-bit samples with no control bits.
- R3: The number of lanes in use is ceiling(M × 2 / Mmax). While only lane 0 is in use, the octets, strobes and valids on lane 1 have no effect on any output.
- R4: Within a lane's frame, octet 2k is the high byte and octet 2k+1 the low byte of word k. Stream s takes word (s mod W) of lane (s div W), where W is the number of words per lane per frame. Stream s is placed at bits [16s+15:16s] of `smp_o`.
- R5: `smp_vld_o` is high for exactly one cycle. That cycle is the one after the clock edge that follows the edge which stored the last octet of the frame on the last lane in use to finish. Lanes may finish at different times. `smp_o` changes only in a cycle where `smp_vld_o` is high.
- R6: A frame on a lane begins with a valid octet that carries the frame-start strobe. The following valid octets fill the frame up to the frame length. Valid octets with no frame in progress, and valid octets beyond the frame length, are ignored. A new frame-start strobe discards the partial frame and starts over.
- R7: In every valid output, the sample slots of streams M and above are zero.
- R8: A mode other than 4, 5 or 6, or M = 0, or M greater than the mode's stream limit, sets `cfg_err_o`. The flag stays set until reset, and `smp_vld_o` stays low while it is set.
- R9: Samples within a stream are placed in strided order: stepping by SI from index 0, each later pass starting one index higher, with SI = 0 treated as 1. Every supported mode carries one sample per stream per frame, so each SI value gives the same stream mapping.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 4 | Mode number |
| m_i | input | 4 | Number of enabled streams M |
| si_i | input | 4 | Sample-interleave factor |
| oct_i | input | 16 | Octets; lane l on bits [8l+7:8l] |
| sof_i | input | 2 | Per-lane frame-start strobe |
| ovld_i | input | 2 | Per-lane octet valid |
| smp_o | output | 128 | Samples; stream s on bits [16s+15:16s] |
| smp_vld_o | output | 1 | One-cycle strobe for a new sample set |
| cfg_err_o | output | 1 | Sticky configuration error |

## Verification
The hardest case to reach is a frame that completes on one lane while the other lane is still partway through its own frame. The finished lane must keep its octets, and must ignore any further non-start octets, until the slow lane catches up. The stimulus reaches this case by delaying the lane 1 frame by several cycles and driving extra octets on lane 0 in the gap. Interrupted frames and noise on an unused lane 1 also exercise the frame collection and the lane-count rules.

// File: rtl/rx_sample_demap.sv
module rx_sample_demap (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [3:0]   mode_i,
  input  logic [3:0]   m_i,
  input  logic [3:0]   si_i,
  input  logic [15:0]  oct_i,
  input  logic [1:0]   sof_i,
  input  logic [1:0]   ovld_i,
  output logic [127:0] smp_o,
  output logic         smp_vld_o,
  output logic         cfg_err_o
);
  localparam int LANES   = 2;
  localparam int OCT_MAX = 8;
  localparam int STREAMS = 8;
  localparam int SW      = 16;
  localparam int SPF     = 1;
  localparam int CW      = $clog2(OCT_MAX + 1);
  localparam int IW      = $clog2(OCT_MAX);

  logic [CW-1:0] f_oct;
  logic [3:0]    mx;
  logic [1:0]    wlog;
  logic          mode_ok;

  always_comb begin
    mode_ok = 1'b1;
    case (mode_i)
      4'd4:    begin f_oct = CW'(2); mx = 4'd2; wlog = 2'd0; end
      4'd5:    begin f_oct = CW'(4); mx = 4'd4; wlog = 2'd1; end
      4'd6:    begin f_oct = CW'(8); mx = 4'd8; wlog = 2'd2; end
      default: begin f_oct = CW'(2); mx = 4'd2; wlog = 2'd0; mode_ok = 1'b0; end
    endcase
  end

  logic       bad_now;
  logic [5:0] lanes_on;
  assign bad_now  = !mode_ok || (m_i == 4'd0) || (m_i > mx);
  assign lanes_on = (6'(m_i) * 6'(LANES) + 6'(mx) - 6'd1) >> (wlog + 2'd1);

  logic [CW-1:0]    cnt  [LANES];
  logic [7:0]       fbuf [LANES][OCT_MAX];
  logic [LANES-1:0] lane_done;
  logic             fire;

  assign fire = &lane_done;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_done[l] = (cnt[l] == f_oct) || (6'(l) >= lanes_on);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt[l] <= '0;
        for (int i = 0; i < OCT_MAX; i++) fbuf[l][i] <= '0;
      end else if (ovld_i[l] && sof_i[l]) begin
        fbuf[l][0] <= oct_i[8*l +: 8];
        cnt[l]     <= CW'(1);
      end else if (fire) begin
        cnt[l] <= '0;
      end else if (ovld_i[l] && cnt[l] != '0 && cnt[l] < f_oct) begin
        fbuf[l][IW'(cnt[l])] <= oct_i[8*l +: 8];
        cnt[l]               <= cnt[l] + CW'(1);
      end
    end
  end

  function automatic int si_slot(input int j, input logic [3:0] si);
    int stp;
    int p;
    stp = (si == 4'd0) ? 1 : int'(si);
    p = 0;
    for (int i = 0; i < SPF; i++)
      if ((i % stp) < (j % stp) || ((i % stp) == (j % stp) && i < j)) p++;
    return p;
  endfunction

  logic [STREAMS*SPF*SW-1:0] smp_d;

  always_comb begin
    smp_d = '0;
    for (int s = 0; s < STREAMS; s++) begin
      for (int j = 0; j < SPF; j++) begin
        int w;
        int ln;
        int k;
        w  = s * SPF + si_slot(j, si_i);
        ln = (w >> wlog) % LANES;
        k  = w & ((1 << wlog) - 1);
        if (s < int'(m_i))
          smp_d[(s*SPF + j)*SW +: SW] = {fbuf[ln][2*k], fbuf[ln][2*k + 1]};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_o     <= '0;
      smp_vld_o <= 1'b0;
      cfg_err_o <= 1'b0;
    end else begin
      cfg_err_o <= cfg_err_o | bad_now;
      smp_vld_o <= fire && !bad_now && !cfg_err_o;
      if (fire && !bad_now && !cfg_err_o) smp_o <= smp_d;
    end
  end
endmodule

// File: rtl/rx_sample_demap_chk.sv
module rx_sample_demap_chk (
  input logic         clk,
  input logic         rst_n,
  input logic [3:0]   m_i,
  input logic [127:0] smp_o,
  input logic         smp_vld_o,
  input logic         cfg_err_o
);
  AST_VLD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    smp_vld_o |=> !smp_vld_o); // R5
  AST_SMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(smp_o) |-> smp_vld_o); // R5
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err_o |=> cfg_err_o); // R8
  AST_ERR_BLOCKS_VLD: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err_o |-> !smp_vld_o); // R8
  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    smp_vld_o |-> ((smp_o >> (16 * $past(m_i))) == 128'd0)); // R7
endmodule

bind rx_sample_demap rx_sample_demap_chk u_chk (
  .clk(clk), .rst_n(rst_n), .m_i(m_i),
  .smp_o(smp_o), .smp_vld_o(smp_vld_o), .cfg_err_o(cfg_err_o)
);

// File: tb/tb_rx_sample_demap.sv
`timescale 1ns/1ps
module tb_rx_sample_demap;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [3:0]   mode = 4'd4, m = 4'd1, si = 4'd1;
  logic [15:0]  oct = '0;
  logic [1:0]   sof = '0, ovld = '0;
  logic [127:0] smp_o;
  logic         smp_vld_o, cfg_err_o;

  rx_sample_demap dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .m_i(m), .si_i(si),
    .oct_i(oct), .sof_i(sof), .ovld_i(ovld),
    .smp_o(smp_o), .smp_vld_o(smp_vld_o), .cfg_err_o(cfg_err_o)
  );

  always #2.5 clk = ~clk;

  int errors = 0, checks = 0, cyc = 0, pulses = 0;
  string tag = "R1";

  int          mc [2];
  logic [7:0]  mb [2][8];
  bit          merr, evld;
  logic [127:0] esmp;

  task automatic model_clear();
    mc[0] = 0; mc[1] = 0; merr = 0; evld = 0; esmp = '0;
    for (int l = 0; l < 2; l++) for (int i = 0; i < 8; i++) mb[l][i] = '0;
  endtask

  task automatic model_step();
    int f, mx, nl, wpl;
    bit ok, bad, fire;
    ok = 1; f = 2; mx = 2;
    case (mode)
      4'd4: begin f = 2; mx = 2; end
      4'd5: begin f = 4; mx = 4; end
      4'd6: begin f = 8; mx = 8; end
      default: ok = 0;
    endcase
    bad = !ok || m == 0 || int'(m) > mx;
    nl  = (int'(m) * 2 + mx - 1) / mx;
    fire = 1;
    for (int l = 0; l < 2; l++) if (l < nl && mc[l] != f) fire = 0;
    evld = 0;
    if (fire && !merr && !bad) begin
      evld = 1;
      esmp = '0;
      wpl = f / 2;
      for (int s = 0; s < int'(m); s++)
        esmp[16*s +: 16] = {mb[s / wpl][2*(s % wpl)], mb[s / wpl][2*(s % wpl) + 1]};
    end
    for (int l = 0; l < 2; l++) begin
      if (ovld[l] && sof[l]) begin
        mb[l][0] = oct[8*l +: 8]; mc[l] = 1;
      end else if (fire) begin
        mc[l] = 0;
      end else if (ovld[l] && mc[l] > 0 && mc[l] < f) begin
        mb[l][mc[l]] = oct[8*l +: 8]; mc[l]++;
      end
    end
    if (bad) merr = 1;
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    if (!rst_n) model_clear(); else model_step();
    #1;
    if (smp_vld_o) pulses++;
    check(smp_vld_o === evld, tag, "valid", 128'(smp_vld_o), 128'(evld));
    check(cfg_err_o === merr, tag, "cfg_err", 128'(cfg_err_o), 128'(merr));
    check(smp_o === esmp, tag, "samples", smp_o, esmp);
  endtask

  task automatic idle();
    ovld = '0; sof = '0; oct = $urandom;
  endtask

  task automatic do_reset();
    idle();
    rst_n = 1'b0;
    tick(); tick();
    rst_n = 1'b1;
  endtask

  task automatic send_frame(input int f, input int nl, input int skew, input bit junk0, input bit junk1);
    for (int t = 0; t < f + skew; t++) begin
      for (int l = 0; l < 2; l++) begin
        int idx;
        idx = t - (l == 1 ? skew : 0);
        if (l < nl && idx >= 0 && idx < f) begin
          ovld[l] = 1; sof[l] = (idx == 0); oct[8*l +: 8] = 8'($urandom);
        end else if ((l == 0 && junk0) || (l == 1 && junk1)) begin
          ovld[l] = 1; sof[l] = 0; oct[8*l +: 8] = 8'($urandom);
        end else begin
          ovld[l] = 0; sof[l] = 0;
        end
      end
      tick();
    end
    idle();
    tick(); tick();
  endtask

  task automatic run(input string t, input int md, input int mm, input int f, input int nl,
                     input int skew, input bit j0, input bit j1, input int frames, input int exp_p);
    tag = t; mode = 4'(md); m = 4'(mm);
    pulses = 0;
    for (int i = 0; i < frames; i++) send_frame(f, nl, skew, j0, j1);
    check(pulses == exp_p, t, "pulse count", 128'(pulses), 128'(exp_p));
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 50000) begin
        errors++; checks++;
        $display("FAIL watchdog: actual=%0d expected<=50000 cycles", cyc);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    model_clear();
    do_reset();
    tag = "R1";
    check(smp_o === '0 && !smp_vld_o && !cfg_err_o, "R1", "reset state",
          {smp_o[125:0], smp_vld_o, cfg_err_o}, 128'd0);

    run("R2", 4, 2, 2, 2, 0, 0, 0, 3, 3);
    run("R4", 5, 4, 4, 2, 0, 0, 0, 3, 3);
    run("R4", 6, 8, 8, 2, 0, 0, 0, 3, 3);
    run("R3", 4, 1, 2, 1, 0, 0, 1, 2, 2);
    run("R3", 6, 4, 8, 1, 0, 0, 1, 2, 2);
    run("R3", 5, 3, 4, 2, 0, 0, 0, 2, 2);
    run("R3", 6, 5, 8, 2, 0, 0, 0, 2, 2);
    run("R7", 6, 3, 8, 1, 0, 0, 0, 2, 2);
    run("R7", 5, 1, 4, 1, 0, 0, 0, 2, 2);
    run("R5", 5, 4, 4, 2, 3, 1, 0, 2, 2);
    run("R5", 6, 8, 8, 2, 5, 1, 0, 2, 2);
    si = 4'd3; run("R9", 5, 4, 4, 2, 0, 0, 0, 2, 2);
    si = 4'd0; run("R9", 6, 8, 8, 2, 0, 0, 0, 2, 2);
    si = 4'd1;

    tag = "R6"; mode = 4'd4; m = 4'd1; pulses = 0;
    for (int i = 0; i < 4; i++) begin
      ovld = 2'b01; sof = '0; oct = $urandom; tick();
    end
    idle(); tick();
    check(pulses == 0, "R6", "no frame without start", 128'(pulses), 128'd0);
    mode = 4'd6; m = 4'd2;
    ovld = 2'b01; sof = 2'b01; oct = $urandom; tick();
    ovld = 2'b01; sof = 2'b00; oct = $urandom; tick();
    ovld = 2'b01; sof = 2'b00; oct = $urandom; tick();
    send_frame(8, 1, 0, 0, 0);
    check(pulses == 1, "R6", "restart frame pulses", 128'(pulses), 128'd1);

    tag = "R8"; pulses = 0;
    mode = 4'd7; m = 4'd1; idle(); tick();
    mode = 4'd4; send_frame(2, 1, 0, 0, 0);
    check(cfg_err_o === 1'b1, "R8", "sticky flag", 128'(cfg_err_o), 128'd1);
    check(pulses == 0, "R8", "valid held low", 128'(pulses), 128'd0);
    do_reset();
    mode = 4'd4; m = 4'd3; send_frame(2, 2, 0, 0, 0);
    check(cfg_err_o === 1'b1, "R8", "M above limit", 128'(cfg_err_o), 128'd1);
    do_reset();
    mode = 4'd5; m = 4'd0; send_frame(4, 1, 0, 0, 0);
    check(cfg_err_o === 1'b1, "R8", "M zero", 128'(cfg_err_o), 128'd1);
    check(pulses == 0, "R8", "no pulses on error", 128'(pulses), 128'd0);
    do_reset();
    run("R8", 5, 2, 4, 1, 0, 0, 0, 1, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule